// File: doc/BRIEF.md
# Full-Duplex Serial Transceiver with Stop Stretching

This block is an asynchronous serial transceiver with a transmitter and a receiver that run independently and at the same time. Both take their bit timing from an internal programmable divider. The divider produces a tick at sixteen times the bit rate. A two-bit length select chooses frames that carry 7, 8 or 9 data bits. The line idles high. Each frame is one low start bit, then the data bits least-significant first, then a high stop period.

The transmitter has one holding register behind a valid/ready write port. If a word is still waiting in that register when a frame reaches the end of its stop bit, the transmitter holds the line high for a second bit time and only then starts the next frame. A frame with nothing queued behind it ends after a single stop bit.

The receiver synchronises the line and takes three votes around the centre of each bit. It drops a start bit that has gone high again by mid-bit. When a frame is complete it presents the data right-aligned, with a one-cycle valid strobe and a flag that marks a stop bit sampled low.

Top module: `sio_xcvr`

## Requirements
- R1: After reset, txd is high, tx_ready is high, tx_busy is low and rx_valid is low.
- R2: A transmitted frame is a low start bit, then the data bits least-significant bit first, then a high stop bit. The line is high while idle.
- R3: The len_sel input picks the number of data bits per frame for both directions: 0 gives 7, 1 gives 8, 2 gives 9 and 3 gives 8. Unused upper bits of tx_data are not sent, and unused upper bits of rx_data read as zero.
- R4: When no word is waiting at the end of a frame, the stop level lasts exactly one bit time, and then tx_busy falls.
- R5: When a word is waiting in the holding register at the end of a frame's stop bit, the line stays high for exactly two bit times in total before the next start bit.
- R6: A write is accepted on a clock where tx_valid and tx_ready are both high. tx_ready is low on the cycle after the write and rises again when the shifter takes the word.
- R7: The divider ticks once every baud_div+1 clocks, and one bit lasts 16 ticks, so a bit time is 16*(baud_div+1) clocks.
- R8: The receiver takes frames of the selected length and presents the data with a one-cycle rx_valid pulse. rx_data and rx_frame_err change only together with that pulse.
- R9: A low pulse on rxd that ends before mid-bit is rejected as a start bit and produces no rx_valid.
- R10: A frame whose stop bit is sampled low is still reported, with rx_frame_err high. A frame with a high stop bit reports rx_frame_err low.
- R11: Transmit and receive run at the same time without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| baud_div | input | 16 | Divider: the tick period is baud_div+1 clocks |
| len_sel | input | 2 | Data length select (0:7, 1:8, 2:9, 3:8) |
| tx_data | input | 9 | Word to transmit |
| tx_valid | input | 1 | Write request for tx_data |
| tx_ready | output | 1 | Holding register is empty |
| tx_busy | output | 1 | Transmit shifter is sending a frame |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_data | output | 9 | Received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for a received frame |
| rx_frame_err | output | 1 | Stop bit of the reported frame was low |

## Verification
The assertions take baud_div and len_sel to be steady while a frame is in flight. They also take tx_valid to be qualified by tx_ready, so the holding register is never overwritten. The bench changes the divisor and the length only while both directions are idle. Every write goes through a task that waits for tx_ready before it raises tx_valid. The serial frames the bench drives into rxd keep to whole bit times at the configured rate.

// File: rtl/sio_pkg.sv
package sio_pkg;
    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_STOP, TX_STOP2
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE, RX_START, RX_DATA, RX_STOP
    } rx_state_e;

    function automatic logic [3:0] frame_bits(input logic [1:0] sel);
        case (sel)
            2'd0:    return 4'd7;
            2'd2:    return 4'd9;
            default: return 4'd8;
        endcase
    endfunction
endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q >= divisor);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7: with a divisor above zero, two ticks never fall on adjacent clocks
    a_r7_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && divisor != '0 && $stable(divisor)) |=> !tick);
endmodule

// File: rtl/sio_tx.sv
module sio_tx
    import sio_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [3:0] nbits,
    input  logic [8:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    output logic       tx_busy,
    output logic       txd
);
    localparam int OSR_W = $clog2(OSR);
    localparam logic [OSR_W-1:0] LAST = OSR_W'(OSR - 1);

    typedef struct packed {
        tx_state_e        state;
        logic [OSR_W-1:0] tcnt;
        logic [3:0]       bidx;
        logic [8:0]       shreg;
        logic [8:0]       hold;
        logic             hold_full;
        logic             line;
    } tx_regs_t;

    tx_regs_t d, q;

    always_comb begin
        d = q;
        if (tx_valid && !q.hold_full) begin
            d.hold      = tx_data;
            d.hold_full = 1'b1;
        end
        case (q.state)
            TX_IDLE: begin
                d.line = 1'b1;
                if (q.hold_full) begin
                    d.state     = TX_START;
                    d.shreg     = q.hold;
                    d.hold_full = 1'b0;
                    d.tcnt      = '0;
                    d.line      = 1'b0;
                end
            end
            TX_START: if (tick) begin
                d.tcnt = q.tcnt + 1'b1;
                if (q.tcnt == LAST) begin
                    d.state = TX_DATA;
                    d.bidx  = '0;
                    d.line  = q.shreg[0];
                end
            end
            TX_DATA: if (tick) begin
                d.tcnt = q.tcnt + 1'b1;
                if (q.tcnt == LAST) begin
                    if (q.bidx == nbits - 4'd1) begin
                        d.state = TX_STOP;
                        d.line  = 1'b1;
                    end else begin
                        d.bidx  = q.bidx + 4'd1;
                        d.shreg = q.shreg >> 1;
                        d.line  = q.shreg[1];
                    end
                end
            end
            TX_STOP: if (tick) begin
                d.tcnt = q.tcnt + 1'b1;
                if (q.tcnt == LAST)
                    d.state = q.hold_full ? TX_STOP2 : TX_IDLE;
            end
            TX_STOP2: if (tick) begin
                d.tcnt = q.tcnt + 1'b1;
                if (q.tcnt == LAST) begin
                    d.state     = TX_START;
                    d.shreg     = q.hold;
                    d.hold_full = 1'b0;
                    d.line      = 1'b0;
                end
            end
            default: d.state = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.line <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign tx_ready = !q.hold_full;
    assign tx_busy  = (q.state != TX_IDLE);
    assign txd      = q.line;

    // R6: an accepted write takes ready low on the next cycle
    a_r6_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);
    // R5: the stretched stop period only runs while a word is queued
    a_r5_stretch_has_word: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == TX_STOP2) |-> !tx_ready);
    // R2: the line is high when the shifter is idle and low during the start bit
    a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == TX_IDLE) |-> txd);
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == TX_START) |-> !txd);
endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [3:0] nbits,
    input  logic       rxd,
    output logic [8:0] rx_data,
    output logic       rx_valid,
    output logic       rx_frame_err
);
    localparam int OSR_W = $clog2(OSR);
    localparam logic [OSR_W-1:0] LAST = OSR_W'(OSR - 1);
    localparam logic [OSR_W-1:0] MID  = OSR_W'(OSR / 2 - 1);
    localparam logic [OSR_W-1:0] MID2 = OSR_W'(OSR / 2 + 1);

    typedef struct packed {
        rx_state_e        state;
        logic [OSR_W-1:0] tcnt;
        logic [3:0]       bidx;
        logic [1:0]       votes;
        logic [8:0]       shreg;
        logic [8:0]       data;
        logic             valid;
        logic             ferr;
        logic [1:0]       sync;
    } rx_regs_t;

    rx_regs_t   d, q;
    logic       line, in_window;
    logic [1:0] vsum;

    always_comb begin
        d         = q;
        line      = q.sync[1];
        d.sync    = {q.sync[0], rxd};
        d.valid   = 1'b0;
        in_window = (q.tcnt >= MID) && (q.tcnt <= MID2);
        vsum      = q.votes + {1'b0, line};
        case (q.state)
            RX_IDLE: if (tick && !line) begin
                d.state = RX_START;
                d.tcnt  = '0;
            end
            RX_START: if (tick) begin
                d.tcnt = q.tcnt + 1'b1;
                if (q.tcnt == MID && line) begin
                    d.state = RX_IDLE;
                end else if (q.tcnt == LAST) begin
                    d.state = RX_DATA;
                    d.bidx  = '0;
                    d.votes = '0;
                end
            end
            RX_DATA: if (tick) begin
                d.tcnt = q.tcnt + 1'b1;
                if (in_window && line) d.votes = vsum;
                if (q.tcnt == LAST) begin
                    d.shreg = {q.votes[1], q.shreg[8:1]};
                    d.votes = '0;
                    if (q.bidx == nbits - 4'd1) d.state = RX_STOP;
                    else                        d.bidx  = q.bidx + 4'd1;
                end
            end
            RX_STOP: if (tick) begin
                d.tcnt = q.tcnt + 1'b1;
                if (in_window && line) d.votes = vsum;
                if (q.tcnt == MID2) begin
                    d.valid = 1'b1;
                    d.ferr  = !vsum[1];
                    d.data  = q.shreg >> (4'd9 - nbits);
                    d.state = RX_IDLE;
                end
            end
            default: d.state = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.sync <= 2'b11;
        end else begin
            q <= d;
        end
    end

    assign rx_data      = q.data;
    assign rx_valid     = q.valid;
    assign rx_frame_err = q.ferr;

    // R8: the strobe lasts a single cycle
    a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    // R8: the outputs move only together with the strobe
    a_r8_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rx_data) || !$stable(rx_frame_err)) |-> rx_valid);
endmodule

// File: rtl/sio_xcvr.sv
module sio_xcvr
    import sio_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int OSR   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] baud_div,
    input  logic [1:0]       len_sel,
    input  logic [8:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic             tx_busy,
    output logic             txd,
    input  logic             rxd,
    output logic [8:0]       rx_data,
    output logic             rx_valid,
    output logic             rx_frame_err
);
    logic       tick;
    logic [3:0] nbits;

    assign nbits = frame_bits(len_sel);

    sio_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .divisor(baud_div), .tick(tick)
    );

    sio_tx #(.OSR(OSR)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .nbits(nbits),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_busy(tx_busy), .txd(txd)
    );

    sio_rx #(.OSR(OSR)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .nbits(nbits), .rxd(rxd),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
    );
endmodule

// File: tb/sio_xcvr_bench.sv
module sio_xcvr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] baud_div = 16'd3;
    logic [1:0]  len_sel = 2'd1;
    logic [8:0]  tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready, tx_busy, txd, rx_valid, rx_frame_err;
    logic [8:0]  rx_data;
    logic        loop = 1'b1;
    logic        rxd_drv = 1'b1;
    logic        rxd;
    int          checks = 0;
    int          fails = 0;

    assign rxd = loop ? txd : rxd_drv;

    always #2 clk = ~clk;

    sio_xcvr u_sio_xcvr (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .len_sel(len_sel),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_busy(tx_busy), .txd(txd), .rxd(rxd), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
    );

    function automatic int bt();
        return 16 * (int'(baud_div) + 1);
    endfunction

    function automatic int nb(input logic [1:0] s);
        return (s == 2'd0) ? 7 : (s == 2'd2) ? 9 : 8;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tx_write(input logic [8:0] v);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_data  = v;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic capture_tx(input int n, output logic [8:0] v, output logic stop_ok,
                              output logic start_ok);
        v = '0;
        while (txd) @(negedge clk);
        wait_cyc(bt() / 2);
        start_ok = !txd;
        for (int i = 0; i < n; i++) begin
            wait_cyc(bt());
            v[i] = txd;
        end
        wait_cyc(bt());
        stop_ok = txd;
    endtask

    task automatic wait_rx(input int limit, output bit got, output logic [8:0] v,
                           output logic fe);
        got = 1'b0;
        v   = '0;
        fe  = 1'b0;
        for (int i = 0; i < limit && !got; i++) begin
            @(negedge clk);
            if (rx_valid) begin
                got = 1'b1;
                v   = rx_data;
                fe  = rx_frame_err;
            end
        end
    endtask

    task automatic send_rx(input logic [8:0] v, input int n, input logic stopv);
        rxd_drv = 1'b0;
        wait_cyc(bt());
        for (int i = 0; i < n; i++) begin
            rxd_drv = v[i];
            wait_cyc(bt());
        end
        rxd_drv = stopv;
        wait_cyc(bt());
        rxd_drv = 1'b1;
    endtask

    task automatic t_reset();
        check(txd == 1'b1, "R1 txd", int'(txd), 1);
        check(tx_ready == 1'b1, "R1 tx_ready", int'(tx_ready), 1);
        check(tx_busy == 1'b0, "R1 tx_busy", int'(tx_busy), 0);
        check(rx_valid == 1'b0, "R1 rx_valid", int'(rx_valid), 0);
    endtask

    // R2, R3, R8: loopback frame at a given length
    task automatic t_loop(input logic [1:0] sel, input logic [8:0] v);
        logic [8:0] cap, got_v, mask;
        logic sok, stok, fe;
        bit got;
        len_sel = sel;
        loop    = 1'b1;
        mask    = 9'((1 << nb(sel)) - 1);
        fork
            tx_write(v);
            capture_tx(nb(sel), cap, sok, stok);
            wait_rx(14 * bt(), got, got_v, fe);
        join
        check(stok, "R2 start low", int'(stok), 1);
        check(sok, "R2 stop high", int'(sok), 1);
        check(cap == (v & mask), "R3 tx bits", int'(cap), int'(v & mask));
        check(got, "R8 rx_valid seen", int'(got), 1);
        check(got_v == (v & mask), "R8 rx data", int'(got_v), int'(v & mask));
        check(!fe, "R10 no frame error", int'(fe), 0);
        wait_cyc(2 * bt());
    endtask

    task automatic t_ready();
        len_sel = 2'd1;
        tx_write(9'h0AA);
        check(!tx_ready, "R6 ready low after write", int'(tx_ready), 0);
        @(negedge clk);
        check(tx_ready, "R6 ready back on load", int'(tx_ready), 1);
        tx_write(9'h055);
        wait_cyc(bt());
        check(!tx_ready, "R6 ready held while word waits", int'(tx_ready), 0);
        while (tx_busy || !tx_ready) @(negedge clk);
        wait_cyc(2 * bt());
    endtask

    // R4: one stop bit on a lone frame (all-zero data makes the stop the first rise)
    task automatic t_single_stop();
        int c = 0;
        len_sel = 2'd1;
        fork
            tx_write(9'h000);
            begin
                while (txd) @(negedge clk);
                while (!txd) @(negedge clk);
                while (tx_busy) begin @(negedge clk); c++; end
            end
        join
        check(c == bt(), "R4 single stop length", c, bt());
        check(txd, "R4 line idle high", int'(txd), 1);
        wait_cyc(bt());
    endtask

    task automatic t_back_to_back();
        int c1 = 0;
        int c2 = 0;
        len_sel = 2'd0;
        fork
            begin tx_write(9'h000); tx_write(9'h000); end
            begin
                while (txd) @(negedge clk);
                while (!txd) @(negedge clk);
                while (txd) begin @(negedge clk); c1++; end
                while (!txd) @(negedge clk);
                while (tx_busy) begin @(negedge clk); c2++; end
            end
        join
        check(c1 == 2 * bt(), "R5 stretched stop", c1, 2 * bt());
        check(c2 == bt(), "R4 last frame one stop", c2, bt());
        wait_cyc(bt());
    endtask

    task automatic t_divisor();
        baud_div = 16'd1;
        wait_cyc(4);
        t_single_stop();
        check(bt() == 32, "R7 bit time at divisor 1", bt(), 32);
        t_loop(2'd1, 9'h0C3);
        baud_div = 16'd3;
        wait_cyc(4);
    endtask

    task automatic t_glitch();
        bit got;
        logic [8:0] v;
        logic fe;
        loop = 1'b0;
        len_sel = 2'd1;
        rxd_drv = 1'b0;
        wait_cyc(bt() / 4);
        rxd_drv = 1'b1;
        wait_rx(12 * bt(), got, v, fe);
        check(!got, "R9 short low pulse rejected", int'(got), 0);
        fork
            send_rx(9'h05A, 8, 1'b1);
            wait_rx(12 * bt(), got, v, fe);
        join
        check(got && v == 9'h05A, "R9 frame after glitch", int'(v), 9'h05A);
    endtask

    task automatic t_frame_err();
        bit got;
        logic [8:0] v;
        logic fe;
        loop = 1'b0;
        len_sel = 2'd2;
        fork
            send_rx(9'h1C6, 9, 1'b0);
            wait_rx(13 * bt(), got, v, fe);
        join
        check(got && fe, "R10 frame error flagged", int'(fe), 1);
        check(v == 9'h1C6, "R10 data with error", int'(v), 9'h1C6);
        wait_cyc(3 * bt());
        fork
            send_rx(9'h039, 9, 1'b1);
            wait_rx(13 * bt(), got, v, fe);
        join
        check(got && !fe, "R10 error clears on good frame", int'(fe), 0);
        wait_cyc(bt());
    endtask

    task automatic t_duplex();
        logic [8:0] cap, v;
        logic sok, stok, fe;
        bit got;
        loop = 1'b0;
        len_sel = 2'd2;
        fork
            tx_write(9'h1A5);
            capture_tx(9, cap, sok, stok);
            send_rx(9'h0F3, 9, 1'b1);
            wait_rx(13 * bt(), got, v, fe);
        join
        check(cap == 9'h1A5, "R11 tx during rx", int'(cap), 9'h1A5);
        check(got && v == 9'h0F3, "R11 rx during tx", int'(v), 9'h0F3);
        wait_cyc(2 * bt());
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_loop(2'd0, 9'h05B);
        t_loop(2'd1, 9'h0A7);
        t_loop(2'd2, 9'h16D);
        t_loop(2'd3, 9'h1FF);
        t_ready();
        t_single_stop();
        t_back_to_back();
        t_divisor();
        t_glitch();
        t_frame_err();
        t_duplex();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule